// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Per-Channel Alignment

This block produces eight pulse-width modulated outputs from a single bus clock. Two shared prescalers divide the bus clock by a power of two, and each of them paces a fixed half of the channels. Every channel has its own counter plus an 8-bit period and an 8-bit duty value. A per-channel alignment bit picks between an edge-aligned waveform, where the counter ramps up and wraps, and a center-aligned waveform, where the counter ramps up and back down.

Software configures the block through a synchronous byte-wide write port. The write port sets the two divider codes, the alignment bits, the channel enables and the period and duty values. Period and duty writes land in holding registers. A running channel moves them into its working copy only when its current period ends, so a waveform in progress is never torn. A disabled channel takes them at once.

Top module: `pwm_octet`

## Requirements
- R1: Writing address 0x00 sets the divider codes: bits 2:0 hold the code for source A and bits 6:4 hold the code for source B. A code n makes its source advance once every 2^n bus clocks, for every n from 0 to 7, and any code may be written at any time.
- R2: Channels whose index has bit 1 clear (0, 1, 4, 5) count on source A. Channels whose index has bit 1 set (2, 3, 6, 7) count on source B. The other source's code has no influence on a channel.
- R3: In edge-aligned mode, with period P, duty D and 0 < D < P, the output repeats every P·2^n bus clocks and is high for D·2^n of them in one unbroken run.
- R4: In center-aligned mode, with 0 < D < P, the output repeats every 2·P·2^n bus clocks and is high for (2·D−1)·2^n of them in one unbroken run. The counter never exceeds the working period.
- R5: Address 0x01 holds the alignment bits, with bit x for channel x: 1 selects center-aligned and 0 selects edge-aligned. After reset every bit is 0.
- R6: A duty of 0 keeps the output constantly low. A duty equal to or above the period, with a period of at least 1, keeps it constantly high.
- R7: Period writes (address 0x08+x) and duty writes (address 0x10+x) to an enabled channel take effect only when its current period ends. A write captured on the very edge where the period ends applies from the period after the next one.
- R8: Address 0x02 holds the enables, with bit x for channel x. A disabled channel drives its output low, holds its counter at zero and takes new period and duty values at once. On being enabled it begins a new period at count zero on the following clock.
- R9: A change of a divider code applies to a running channel without disabling it, and the next whole period already uses the new rate.
- R10: After reset all outputs are low and all channels are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 8 | PWM outputs, bit x belongs to channel x |

## Verification
A duty or period write can land on the same clock edge on which the channel's period ends and the working values are reloaded. The bench provokes this by writing a new duty exactly in the last bus cycle of an edge-aligned period. It then requires that the next pulse still shows the old width and that only the pulse after that shows the new one. A second collision, a write arriving one cycle into a pulse, must leave that pulse at its old width. The full sweep measures pulse and gap widths against arithmetic expectations for every channel, both alignments, several divider codes and all duty values from 0 to P+1.

// File: rtl/pwm_octet_pkg.sv
package pwm_octet_pkg;

   // write port map
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned DATA_W = 8;

   localparam logic [ADDR_W-1:0] ADDR_CLKSEL = 5'h00;
   localparam logic [ADDR_W-1:0] ADDR_ALIGN  = 5'h01;
   localparam logic [ADDR_W-1:0] ADDR_ENABLE = 5'h02;
   localparam logic [ADDR_W-1:0] ADDR_PERIOD = 5'h08;
   localparam logic [ADDR_W-1:0] ADDR_DUTY   = 5'h10;

   // bit position of source B code inside the clock select byte
   localparam int unsigned SEL_B_LSB = 4;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } cnt_dir_e;

endpackage

// File: rtl/pwm_octet_regs.sv
module pwm_octet_regs
   import pwm_octet_pkg::*;
#(
   parameter int unsigned CH_COUNT = 8,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned SEL_W    = 3
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             wr_en_i,
   input  logic [ADDR_W-1:0]                wr_addr_i,
   input  logic [DATA_W-1:0]                wr_data_i,
   output logic [SEL_W-1:0]                 sel_a_o,
   output logic [SEL_W-1:0]                 sel_b_o,
   output logic [CH_COUNT-1:0]              align_o,
   output logic [CH_COUNT-1:0]              enable_o,
   output logic [CH_COUNT-1:0][CNT_W-1:0]   per_o,
   output logic [CH_COUNT-1:0][CNT_W-1:0]   duty_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_a_o  <= '0;
         sel_b_o  <= '0;
         align_o  <= '0;
         enable_o <= '0;
      end else if (wr_en_i) begin
         unique case (wr_addr_i)
            ADDR_CLKSEL: begin
               sel_a_o <= wr_data_i[SEL_W-1:0];
               sel_b_o <= wr_data_i[SEL_B_LSB +: SEL_W];
            end
            ADDR_ALIGN:  align_o  <= wr_data_i[CH_COUNT-1:0];
            ADDR_ENABLE: enable_o <= wr_data_i[CH_COUNT-1:0];
            default: ;
         endcase
      end
   end

   // holding registers, one pair per channel
   for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_hold
      localparam logic [ADDR_W-1:0] PER_ADDR  = ADDR_PERIOD + ADDR_W'(ch);
      localparam logic [ADDR_W-1:0] DUTY_ADDR = ADDR_DUTY + ADDR_W'(ch);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            per_o[ch]  <= '0;
            duty_o[ch] <= '0;
         end else if (wr_en_i) begin
            if (wr_addr_i == PER_ADDR)  per_o[ch]  <= wr_data_i[CNT_W-1:0];
            if (wr_addr_i == DUTY_ADDR) duty_o[ch] <= wr_data_i[CNT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/pwm_octet_prescaler.sv
module pwm_octet_prescaler #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   // a code n needs n low bits of the divider; the largest code sets the width
   localparam int unsigned DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= '0;
      else         div_q <= div_q + DIV_W'(1);
   end

   // the lowest n divider bits all set marks the end of one 2^n stretch
   always_comb begin
      for (int i = 0; i < DIV_W; i++) begin
         mask[i] = (i < int'(sel_i));
      end
   end

   assign tick_o = ((div_q & mask) == mask);

   // R1: with a code of 1 or more, no two ticks come back to back unless the code moved
   assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && sel_i != '0) |=> (!tick_o || !$stable(sel_i)));

endmodule

// File: rtl/pwm_octet_channel.sv
module pwm_octet_channel
   import pwm_octet_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             center_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] per_hold_i,
   input  logic [CNT_W-1:0] duty_hold_i,
   output logic             pwm_o
);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] per_q, duty_q;
   cnt_dir_e         dir_q, dir_d;
   logic             wrap;

   // next count and end-of-period detection
   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      wrap  = 1'b0;
      if (per_q == '0) begin
         cnt_d = '0;
         dir_d = DIR_UP;
         wrap  = 1'b1;
      end else if (!center_i) begin
         dir_d = DIR_UP;
         if (cnt_q >= per_q - CNT_W'(1)) begin
            cnt_d = '0;
            wrap  = 1'b1;
         end else begin
            cnt_d = cnt_q + CNT_W'(1);
         end
      end else if (dir_q == DIR_DOWN || cnt_q >= per_q) begin
         if (cnt_q <= CNT_W'(1)) begin
            cnt_d = '0;
            dir_d = DIR_UP;
            wrap  = 1'b1;
         end else begin
            cnt_d = cnt_q - CNT_W'(1);
            dir_d = DIR_DOWN;
         end
      end else begin
         cnt_d = cnt_q + CNT_W'(1);
         dir_d = DIR_UP;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         dir_q  <= DIR_UP;
         per_q  <= '0;
         duty_q <= '0;
      end else if (!en_i) begin
         cnt_q  <= '0;
         dir_q  <= DIR_UP;
         per_q  <= per_hold_i;
         duty_q <= duty_hold_i;
      end else if (tick_i) begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
         if (wrap) begin
            per_q  <= per_hold_i;
            duty_q <= duty_hold_i;
         end
      end
   end

   assign pwm_o = en_i && (duty_q != '0) && ((duty_q >= per_q) || (cnt_q < duty_q));

   // R8: a disabled channel sits at count zero on the next edge
   assert_idle_at_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0));

   // R4: the counter stays within the working period in either mode
   assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= per_q);

   // R7: a running channel keeps its working duty until its period ends
   assert_duty_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !(tick_i && wrap)) |=> $stable(duty_q));

   // R7: the same holds for the working period
   assert_period_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !(tick_i && wrap)) |=> $stable(per_q));

endmodule

// File: rtl/pwm_octet.sv
module pwm_octet
   import pwm_octet_pkg::*;
#(
   parameter int unsigned CH_COUNT = 8,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned SEL_W    = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   wr_addr_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [CH_COUNT-1:0] pwm_o
);

   // elaboration checks on the parameters
   if (CH_COUNT != 4 && CH_COUNT != 8) begin : g_bad_ch_count
      $error("pwm_octet: CH_COUNT must be 4 or 8");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("pwm_octet: CNT_W must lie between 2 and the data width");
   end
   if (SEL_W < 1 || SEL_W > SEL_B_LSB - 1) begin : g_bad_sel_w
      $error("pwm_octet: SEL_W must lie between 1 and 3");
   end

   logic [SEL_W-1:0]               sel_a, sel_b;
   logic [CH_COUNT-1:0]            align, enable;
   logic [CH_COUNT-1:0][CNT_W-1:0] per_hold, duty_hold;
   logic                           tick_a, tick_b;

   pwm_octet_regs #(
      .CH_COUNT (CH_COUNT),
      .CNT_W    (CNT_W),
      .SEL_W    (SEL_W)
   ) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .sel_a_o   (sel_a),
      .sel_b_o   (sel_b),
      .align_o   (align),
      .enable_o  (enable),
      .per_o     (per_hold),
      .duty_o    (duty_hold)
   );

   pwm_octet_prescaler #(.SEL_W(SEL_W)) div_a_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel_a),
      .tick_o (tick_a)
   );

   pwm_octet_prescaler #(.SEL_W(SEL_W)) div_b_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel_b),
      .tick_o (tick_b)
   );

   for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_ch
      logic ch_tick;

      // index bit 1 selects the clock group
      if (((ch >> 1) & 1) == 1) begin : g_src_b
         assign ch_tick = tick_b;
      end else begin : g_src_a
         assign ch_tick = tick_a;
      end

      pwm_octet_channel #(.CNT_W(CNT_W)) chan_i (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .en_i        (enable[ch]),
         .center_i    (align[ch]),
         .tick_i      (ch_tick),
         .per_hold_i  (per_hold[ch]),
         .duty_hold_i (duty_hold[ch]),
         .pwm_o       (pwm_o[ch])
      );
   end

   // R10: a channel whose enable was clear a cycle ago and still is stays low
   assert_off_stays_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(enable) == '0 && enable == '0) |-> (pwm_o == '0));

endmodule

// File: tb/pwm_octet_tb_top.sv
module pwm_octet_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] pwm;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   pwm_octet dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .pwm_o     (pwm)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // returns at a negedge where channel ch has just gone high
   task automatic wait_rise(input int ch, output bit ok);
      int t = 0;
      while (pwm[ch] !== 1'b0 && t < 5000) begin
         @(negedge clk); wr_en = 1'b0; t++;
      end
      while (pwm[ch] !== 1'b1 && t < 5000) begin
         @(negedge clk); wr_en = 1'b0; t++;
      end
      ok = (t < 5000);
   endtask

   // counts samples equal to v, starting with the current one
   task automatic run_len(input int ch, input logic v, output int len);
      len = 0;
      while (pwm[ch] === v && len < 5000) begin
         len++;
         @(negedge clk); wr_en = 1'b0;
      end
   endtask

   task automatic cfg(input int ch, input int p, input int d, input int n, input int al);
      int other;
      logic [2:0] sa, sb;
      other = (n == 0) ? 3 : 0;
      if (((ch >> 1) & 1) == 1) begin sb = 3'(n); sa = 3'(other); end
      else                      begin sa = 3'(n); sb = 3'(other); end
      wr(5'h02, 8'h00);
      wr(5'(8 + ch), 8'(p));
      wr(5'(16 + ch), 8'(d));
      wr(5'h01, 8'(al << ch));
      wr(5'h00, {1'b0, sb, 1'b0, sa});
      wr(5'h02, 8'(1 << ch));
   endtask

   task automatic measure(input int ch, input int p, input int d, input int n, input int al);
      int scale, h, l, bad, win;
      bit ok;
      string req;
      scale = 1 << n;
      req = (al != 0) ? "R4/R2/R1" : "R3/R2/R1";
      if (d == 0 || d >= p) begin
         win = 4 * p * scale + 8;
         bad = 0;
         for (int i = 0; i < win; i++) begin
            if (pwm[ch] !== ((d == 0) ? 1'b0 : 1'b1)) bad++;
            @(negedge clk);
         end
         chk(bad == 0, "R6 constant level", bad, 0);
      end else begin
         wait_rise(ch, ok);
         chk(ok, req, int'(ok), 1);
         run_len(ch, 1'b1, h);
         run_len(ch, 1'b0, l);
         if (al != 0) begin
            chk(h == (2 * d - 1) * scale, {req, " high"}, h, (2 * d - 1) * scale);
            chk(l == (2 * p - 2 * d + 1) * scale, {req, " low"}, l, (2 * p - 2 * d + 1) * scale);
         end else begin
            chk(h == d * scale, {req, " high"}, h, d * scale);
            chk(l == (p - d) * scale, {req, " low"}, l, (p - d) * scale);
         end
      end
   endtask

   initial begin
      int h, l, bad;
      bit ok;
      repeat (3) @(negedge clk);
      chk(pwm == 8'h00, "R10 outputs in reset", int'(pwm), 0);
      rst_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (pwm !== 8'h00) bad++;
      end
      chk(bad == 0, "R10 outputs low after reset", bad, 0);

      // R5: alignment resets to edge-aligned; no alignment write here
      wr(5'h0B, 8'd3);
      wr(5'h13, 8'd1);
      wr(5'h02, 8'h08);
      wait_rise(3, ok);
      run_len(3, 1'b1, h);
      run_len(3, 1'b0, l);
      chk(h == 1 && l == 2, "R5 default alignment high", h, 1);
      chk(l == 2, "R5 default alignment low", l, 2);

      // sweep: all channels, both alignments, two divider codes, all duties
      for (int ch = 0; ch < 8; ch++) begin
         for (int al = 0; al < 2; al++) begin
            for (int n = 0; n <= 2; n += 2) begin
               for (int p = 1; p <= 5; p += 2) begin
                  for (int d = 0; d <= p + 1; d++) begin
                     cfg(ch, p, d, n, al);
                     measure(ch, p, d, n, al);
                  end
               end
            end
         end
      end

      // R1: extreme divider codes on both sources
      cfg(0, 2, 1, 5, 0);
      measure(0, 2, 1, 5, 0);
      cfg(6, 2, 1, 7, 0);
      measure(6, 2, 1, 7, 0);

      // R7: duty write one cycle into a pulse keeps the running pulse
      cfg(5, 8, 2, 0, 0);
      wait_rise(5, ok);
      wr_addr = 5'h15; wr_data = 8'd6; wr_en = 1'b1;
      run_len(5, 1'b1, h);
      run_len(5, 1'b0, l);
      chk(h == 2, "R7 running pulse keeps old duty", h, 2);
      chk(l == 6, "R7 running gap keeps old duty", l, 6);
      run_len(5, 1'b1, h);
      run_len(5, 1'b0, l);
      chk(h == 6 && l == 2, "R7 next period uses new duty", h, 6);

      // R7: write captured on the wrap edge applies one period later
      cfg(2, 4, 2, 0, 0);
      wait_rise(2, ok);
      run_len(2, 1'b1, h);
      @(negedge clk);
      wr_addr = 5'h12; wr_data = 8'd3; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(pwm[2] === 1'b1, "R7 new period starts on wrap", int'(pwm[2]), 1);
      run_len(2, 1'b1, h);
      run_len(2, 1'b0, l);
      chk(h == 2 && l == 2, "R7 same-edge write not yet applied", h, 2);
      run_len(2, 1'b1, h);
      chk(h == 3, "R7 same-edge write applied after", h, 3);

      // R8: enable starts at count zero, disable drops output, idle load
      cfg(1, 6, 3, 0, 0);
      chk(pwm[1] === 1'b1, "R8 output high right after enable", int'(pwm[1]), 1);
      run_len(1, 1'b1, h);
      chk(h == 3, "R8 first pulse full width", h, 3);
      wait_rise(1, ok);
      @(negedge clk);
      wr(5'h02, 8'h00);
      chk(pwm[1] === 1'b0, "R8 output low once disabled", int'(pwm[1]), 0);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (pwm !== 8'h00) bad++;
      end
      chk(bad == 0, "R8 disabled stays low", bad, 0);
      wr(5'h11, 8'd1);
      wr(5'h02, 8'h02);
      run_len(1, 1'b1, h);
      run_len(1, 1'b0, l);
      chk(h == 1 && l == 5, "R8 idle write taken at once", h, 1);

      // R9: divider change on a running channel
      cfg(4, 4, 2, 0, 0);
      wait_rise(4, ok);
      wr(5'h00, 8'h02);
      wait_rise(4, ok);
      run_len(4, 1'b1, h);
      run_len(4, 1'b0, l);
      chk(h == 8, "R9 high after divider change", h, 8);
      chk(l == 8, "R9 low after divider change", l, 8);

      // R2: source B code alone moves a group B channel
      cfg(7, 3, 1, 1, 0);
      wr(5'h00, 8'h17);
      wait_rise(7, ok);
      run_len(7, 1'b1, h);
      run_len(7, 1'b0, l);
      chk(h == 2 && l == 4, "R2 group B ignores source A code", h, 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule